// File: doc/BRIEF.md
# Read Port Chip-Select Output Control

This block sits on the read side of a FIFO and decides when the read data bus may be driven and when a word is actually taken from storage. A registered bus enable is built from an active-low chip select and combined with an asynchronous active-low output enable, while a reset override lets output enable alone control the drive during reset and up to the first read clock edge after it. Chip select gates only the drive and the read handshake. The ready flag and the loading of the output register ignore it.

Two read disciplines are supported, and the choice is captured while reset is asserted. In standard mode a word moves into the output register only when it is read. In first-word-fall-through mode the head of storage is loaded into the output register as soon as it exists, even while chip select is inactive, so that word is never lost. A read is accepted only once chip select has been active for a full cycle. A read enable that arrives together with a fresh chip select is rejected and reported as a protocol error. Retransmit requests are granted only while chip select is active.

Top module: `rdp_cs_top`

## Requirements
- R1: Out of reset, with oe_n low, q_drive takes the value of the inverted cs_n sampled at the latest rising clk edge. With oe_n high, q_drive is 0.
- R2: While rst is high, q_drive equals the inverse of oe_n whatever cs_n does.
- R3: After rst falls, q_drive stays equal to the inverse of oe_n until the first rising clk edge. From that edge on, cs_n high turns the drive off.
- R4: word_rdy does not depend on cs_n. In standard mode it is the inverse of store_empty registered at each clk edge. In fall-through mode it is 1 while the output register holds an unread word.
- R5: In fall-through mode, a word that reaches an empty output register is loaded at the next clk edge (rd_strobe high in that cycle), even with cs_n high.
- R6: A read is accepted only in a cycle where cs_n and ren_n are both low and cs_n was also low at the previous edge. rd_strobe is never high in standard mode otherwise.
- R7: proto_err is 1 for one cycle after an edge where ren_n was low in the first cycle of cs_n being low (cs_n high at the edge before). That read is not performed.
- R8: rt_grant is 1 after an edge where rt_req and low cs_n were both present, and 0 otherwise.
- R9: fwft_sel is sampled only while rst is high (1 = fall-through, 0 = standard). Changing it later has no effect. In standard mode no word enters q_data without an accepted read.
- R10: q_data holds its value in every cycle without rd_strobe.
- R11: In standard mode a read attempt on empty storage raises no rd_strobe and leaves q_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| ren_n | input | 1 | Active-low read enable |
| oe_n | input | 1 | Active-low asynchronous output enable |
| fwft_sel | input | 1 | Mode select, captured during reset |
| rt_req | input | 1 | Retransmit request |
| store_empty | input | 1 | Storage holds no word |
| store_data | input | DW | Head word of storage |
| rd_strobe | output | 1 | Pop the head word from storage this cycle |
| q_data | output | DW | Output data register |
| q_drive | output | 1 | Drive enable for the data bus |
| word_rdy | output | 1 | Ready flag (not-empty or output-valid) |
| proto_err | output | 1 | Read enable arrived with a fresh chip select |
| rt_grant | output | 1 | Retransmit accepted |

## Verification
rd_strobe is combinational and is sampled in the same cycle as its stimulus, before the clock edge. q_drive, proto_err, rt_grant, word_rdy and a loaded q_data are all due one rising edge after the inputs that cause them. The standard-mode ready flag drops one edge later than the pop that empties storage, because it registers store_empty. The reset override on q_drive is checked both inside reset and in the gap between rst falling and the next edge. Inputs change on the falling edge and outputs are read on the following falling edge, so each check sits exactly one register stage after its cause.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rdp_mode_e;

    typedef struct packed {
        logic bus_en;   // registered chip-select activity
        logic hold;     // reset override still in force
        logic rd_req;   // qualified read request this cycle
    } rdp_cs_t;

    function automatic logic cs_first_cycle(input logic cs_act, input logic bus_en_prev);
        return cs_act && !bus_en_prev;
    endfunction

endpackage

// File: rtl/rdp_cs_gate.sv
module rdp_cs_gate
    import rdp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    ren_n,
    input  logic    oe_n,
    input  logic    rt_req,
    output rdp_cs_t cs_st,
    output logic    q_drive,
    output logic    proto_err,
    output logic    rt_grant
);
    logic bus_en_q;
    logic hold_q;
    logic err_q;
    logic rt_q;
    logic cs_act;

    assign cs_act = !cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_en_q <= 1'b0;
            hold_q   <= 1'b1;
            err_q    <= 1'b0;
            rt_q     <= 1'b0;
        end else begin
            bus_en_q <= cs_act;
            hold_q   <= 1'b0;
            err_q    <= cs_first_cycle(cs_act, bus_en_q) && !ren_n;
            rt_q     <= cs_act && rt_req;
        end
    end

    always_comb begin
        cs_st.bus_en = bus_en_q;
        cs_st.hold   = hold_q;
        cs_st.rd_req = !rst && cs_act && !ren_n && bus_en_q;
    end

    assign q_drive   = !oe_n && (rst || hold_q || bus_en_q);
    assign proto_err = err_q;
    assign rt_grant  = rt_q;

endmodule

// File: rtl/rdp_out_stage.sv
module rdp_out_stage
    import rdp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_sel,
    input  logic          rd_req,
    input  logic          store_empty,
    input  logic [DW-1:0] store_data,
    output logic          rd_strobe,
    output logic [DW-1:0] q_data,
    output logic          word_rdy,
    output rdp_mode_e     mode
);
    rdp_mode_e     mode_q;
    logic          valid_q;
    logic          rdy_q;
    logic [DW-1:0] data_q;
    logic          read_acc;
    logic          fill;

    always_comb begin
        read_acc = 1'b0;
        fill     = 1'b0;
        if (!rst) begin
            if (mode_q == MODE_FWFT) begin
                read_acc = rd_req && valid_q;
                fill     = !store_empty && (!valid_q || read_acc);
            end else begin
                read_acc = rd_req && !store_empty;
                fill     = read_acc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= rdp_mode_e'(fwft_sel);
            valid_q <= 1'b0;
            rdy_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            if (fill) begin
                data_q <= store_data;
            end
            if (fill) begin
                valid_q <= 1'b1;
            end else if (read_acc) begin
                valid_q <= 1'b0;
            end
            rdy_q <= !store_empty;
        end
    end

    assign rd_strobe = fill;
    assign q_data    = data_q;
    assign word_rdy  = (mode_q == MODE_FWFT) ? valid_q : rdy_q;
    assign mode      = mode_q;

endmodule

// File: rtl/rdp_cs_top.sv
module rdp_cs_top
    import rdp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          ren_n,
    input  logic          oe_n,
    input  logic          fwft_sel,
    input  logic          rt_req,
    input  logic          store_empty,
    input  logic [DW-1:0] store_data,
    output logic          rd_strobe,
    output logic [DW-1:0] q_data,
    output logic          q_drive,
    output logic          word_rdy,
    output logic          proto_err,
    output logic          rt_grant
);
    rdp_cs_t   cs_st;
    rdp_mode_e mode;

    rdp_cs_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .ren_n     (ren_n),
        .oe_n      (oe_n),
        .rt_req    (rt_req),
        .cs_st     (cs_st),
        .q_drive   (q_drive),
        .proto_err (proto_err),
        .rt_grant  (rt_grant)
    );

    rdp_out_stage #(.DW(DW)) u_out (
        .clk         (clk),
        .rst         (rst),
        .fwft_sel    (fwft_sel),
        .rd_req      (cs_st.rd_req),
        .store_empty (store_empty),
        .store_data  (store_data),
        .rd_strobe   (rd_strobe),
        .q_data      (q_data),
        .word_rdy    (word_rdy),
        .mode        (mode)
    );

endmodule

// File: rtl/rdp_cs_chk.sv
module rdp_cs_chk
    import rdp_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          ren_n,
    input logic          oe_n,
    input logic          rt_req,
    input logic          rd_strobe,
    input logic [DW-1:0] q_data,
    input logic          q_drive,
    input logic          proto_err,
    input logic          rt_grant,
    input rdp_mode_e     mode
);
    p_drive_needs_oe_r1: assert property (@(posedge clk) disable iff (rst)
        q_drive |-> !oe_n);

    p_drive_follows_cs_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !oe_n) |-> (q_drive == $past(!cs_n)));

    p_reset_drive_r2: assert property (@(posedge clk)
        rst |-> (q_drive == !oe_n));

    p_std_read_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && mode == MODE_STD) |-> (!cs_n && !ren_n && !$past(cs_n)));

    p_fresh_cs_err_r7: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ren_n && cs_n == 1'b0 && q_drive == 1'b0 && !oe_n) |=> proto_err);

    p_rt_grant_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rt_grant) |-> $past(!cs_n && rt_req));

    p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_strobe)) |-> $stable(q_data));

endmodule

bind rdp_cs_top rdp_cs_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .ren_n     (ren_n),
    .oe_n      (oe_n),
    .rt_req    (rt_req),
    .rd_strobe (rd_strobe),
    .q_data    (q_data),
    .q_drive   (q_drive),
    .proto_err (proto_err),
    .rt_grant  (rt_grant),
    .mode      (mode)
);

// File: tb/rdp_cs_top_tb.sv
module rdp_cs_top_tb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          ren_n = 1'b1;
    logic          oe_n = 1'b0;
    logic          fwft_sel = 1'b1;
    logic          rt_req = 1'b0;
    logic          store_empty;
    logic [DW-1:0] store_data;
    logic          rd_strobe;
    logic [DW-1:0] q_data;
    logic          q_drive;
    logic          word_rdy;
    logic          proto_err;
    logic          rt_grant;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DW-1:0] mem [16];
    int wr_i = 0;
    int rd_i = 0;
    logic [DW-1:0] exp_q [$];

    always #10 clk = ~clk;

    assign store_empty = (wr_i == rd_i);
    assign store_data  = mem[rd_i % 16];

    always @(posedge clk) if (rd_strobe) rd_i <= rd_i + 1;

    rdp_cs_top #(.DW(DW)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ren_n(ren_n), .oe_n(oe_n),
        .fwft_sel(fwft_sel), .rt_req(rt_req), .store_empty(store_empty),
        .store_data(store_data), .rd_strobe(rd_strobe), .q_data(q_data),
        .q_drive(q_drive), .word_rdy(word_rdy), .proto_err(proto_err),
        .rt_grant(rt_grant)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // driver: word enters storage, expected output pushed to scoreboard
    task automatic put_word(input logic [DW-1:0] w);
        mem[wr_i % 16] = w;
        wr_i = wr_i + 1;
        exp_q.push_back(w);
    endtask

    // monitor side: q_data must carry the oldest outstanding word
    task automatic expect_word(input string req);
        logic [DW-1:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
        chk(req, q_data, e);
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1; cs_n = 1'b1; ren_n = 1'b1; fwft_sel = mode;
        tick(); tick();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // ---------- fall-through mode ----------
        @(negedge clk);
        do_reset(1'b1);
        chk("R2 reset drive oe low", q_drive, 1);
        oe_n = 1'b1; #1;
        chk("R2 reset drive oe high", q_drive, 0);
        oe_n = 1'b0;
        chk("R4 reset ready", word_rdy, 0);
        chk("R7 reset err", proto_err, 0);
        rst = 1'b0; #1;
        chk("R3 override before edge", q_drive, 1);
        tick();
        chk("R3 cs high after edge", q_drive, 0);

        put_word(16'hA001); #1;
        chk("R5 fall-through strobe cs high", rd_strobe, 1);
        tick();
        chk("R4 ready with cs high", word_rdy, 1);
        chk("R1 drive off cs high", q_drive, 0);
        expect_word("R5 fallen word");
        put_word(16'hB002);
        tick(); tick();
        chk("R10 held while unread", q_data, 16'hA001);
        cs_n = 1'b0;
        tick();
        chk("R1 drive on cs low", q_drive, 1);
        oe_n = 1'b1; #1;
        chk("R1 oe high blocks drive", q_drive, 0);
        oe_n = 1'b0;
        chk("R6 no read ren high", rd_strobe, 0);
        ren_n = 1'b0; #1;
        chk("R6 read strobe", rd_strobe, 1);
        tick();
        expect_word("R6 next word");
        chk("R7 no err established cs", proto_err, 0);
        tick();
        chk("R4 ready drops after last read", word_rdy, 0);
        ren_n = 1'b1; cs_n = 1'b1;
        tick();
        chk("R1 drive off again", q_drive, 0);
        put_word(16'hC003);
        tick();
        expect_word("R5 second fall-through");
        cs_n = 1'b0; ren_n = 1'b0;
        tick();
        chk("R7 err on fresh cs", proto_err, 1);
        chk("R7 read blocked", word_rdy, 1);
        tick();
        chk("R7 err clears", proto_err, 0);
        chk("R6 read after one cycle", word_rdy, 0);
        ren_n = 1'b1; cs_n = 1'b1; rt_req = 1'b1;
        tick();
        chk("R8 rt refused cs high", rt_grant, 0);
        cs_n = 1'b0;
        tick();
        chk("R8 rt granted cs low", rt_grant, 1);
        rt_req = 1'b0;
        tick();
        chk("R8 rt drops", rt_grant, 0);

        // ---------- standard mode ----------
        do_reset(1'b0);
        rst = 1'b0; fwft_sel = 1'b1;
        tick();
        put_word(16'hD004);
        tick();
        chk("R4 std ready cs high", word_rdy, 1);
        chk("R9 no load without read", q_data, 16'h0000);
        ren_n = 1'b0; #1;
        chk("R6 cs high blocks read", rd_strobe, 0);
        ren_n = 1'b1; cs_n = 1'b0;
        tick();
        ren_n = 1'b0; #1;
        chk("R6 std read strobe", rd_strobe, 1);
        tick();
        expect_word("R6 std word");
        chk("R4 std ready one more", word_rdy, 1);
        chk("R11 empty no strobe", rd_strobe, 0);
        tick();
        chk("R4 std ready off", word_rdy, 0);
        chk("R11 data kept", q_data, 16'hD004);
        ren_n = 1'b1;

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule